// File: doc/BRIEF.md
# Speculative Store Forwarding Cache

While a core runs ahead past a blocking miss, stores that pseudo-retire must not touch architectural memory. Later speculative loads may still need their values. This block is a small direct-mapped buffer that holds those values. Each pseudo-retired store writes an address, a byte-enable mask, up to eight data bytes and a poison flag. The poison flag marks a value that depends on the outstanding miss.

A speculative load presents a line address and the mask of bytes it needs. One cycle later the block returns a hit flag, the whole line of data and a poison flag. The poison flag is the OR of the poison bits of the requested bytes, so a load inherits invalidity from the store data it consumes. On a miss, the consumer takes its value from the ordinary cache path. The results are only hints. Conflict evictions and lost data are allowed, and no recovery is ever triggered. A one-cycle clear pulse at the end of the speculative episode empties every line. The default size is 64 lines of 8 bytes, which is 512 bytes of data.

Top module: `spec_fwd_cache`

## Requirements
- R1: After reset every line is empty, and `rd_hit` and `rd_inv` are 0.
- R2: After a write with byte mask `wr_be`, a read of the same line whose mask is covered by the written bytes hits, and returns the written bytes. Byte b of a line sits in bits [8b+7:8b] of `wr_data` and `rd_data`.
- R3: A read hits only when the line's stored tag equals the address tag and every byte named in `rd_be` is valid. Either a tag mismatch or a missing requested byte gives `rd_hit`=0.
- R4: On a hit, `rd_inv` is the OR of the poison bits of the requested bytes only.
- R5: A write to a line that already holds the same tag changes only the enabled bytes and their poison bits. The other bytes keep their data, valid and poison state. A write with `wr_be`=0 has no effect.
- R6: The address is split into byte offset bits [2:0] (ignored), index bits [8:3] and tag bits [31:9]. A write whose tag differs from the tag held at its index replaces the line, and only the newly written bytes are then valid.
- R7: A clear pulse invalidates every line at that clock edge. A write presented in the same cycle as a clear is dropped.
- R8: Read results appear on the clock edge after the request. They reflect the contents before any write or clear taken at that same edge.
- R9: With `rd_en`=0 or `rd_be`=0, the next `rd_hit` is 0. Whenever `rd_hit` is 0, `rd_inv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | End-of-episode clear pulse |
| wr_en | input | 1 | Pseudo-retired store write strobe |
| wr_addr | input | 32 | Store byte address (line selected by bits above the offset) |
| wr_be | input | 8 | Byte enables within the line |
| wr_data | input | 64 | Store data, byte b in bits [8b+7:8b] |
| wr_inv | input | 1 | Poison flag of the store |
| rd_en | input | 1 | Speculative load lookup strobe |
| rd_addr | input | 32 | Load byte address |
| rd_be | input | 8 | Bytes the load needs |
| rd_hit | output | 1 | Registered: all requested bytes present under matching tag |
| rd_data | output | 64 | Registered line data, meaningful on hit for requested bytes |
| rd_inv | output | 1 | Registered OR of poison bits of requested bytes |

## Verification
Directed sequences use full-line writes, split-half writes with different poison flags and sub-mask reads. These show that the returned poison comes from the requested bytes alone and that partial updates leave the neighbouring bytes intact. Reads at a conflicting index with another tag, and reads that ask for one byte more than was written, separate the tag condition of a hit from the byte-coverage condition. Write and read in the same cycle, a clear with a write in the same cycle, and a write with an empty mask pin down the ordering at a single edge. A random phase over a few tags that share indices then mixes all of these against the bench's own model of lines held by address.

// File: rtl/spec_fwd_pkg.sv
package spec_fwd_pkg;
  localparam int unsigned BYTE_W = 8;

  // Spread one flag over every enabled lane
  function automatic logic [63:0] lane_fill(input logic flag);
    return {64{flag}};
  endfunction
endpackage

// File: rtl/sfc_meta.sv
module sfc_meta #(
  parameter int unsigned LINES = 64,
  parameter int unsigned LANES = 8,
  parameter int unsigned TAG_W = 23,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [LANES-1:0] wr_be,
  input  logic             wr_inv,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [LANES-1:0] rd_be,
  output logic             hit_q,
  output logic             inv_q
);
  import spec_fwd_pkg::*;

  logic [TAG_W-1:0] tag_r [LINES];
  logic [LANES-1:0] vld_r [LINES];
  logic [LANES-1:0] psn_r [LINES];

  logic             wr_go;
  logic             wr_same;
  logic [LANES-1:0] wr_fill;

  assign wr_go   = wr_en && (wr_be != '0) && !clr && !rst;
  assign wr_same = (vld_r[wr_idx] != '0) && (tag_r[wr_idx] == wr_tag);
  assign wr_fill = wr_be & lane_fill(wr_inv)[LANES-1:0];

  // Tag store: no reset needed, qualified by valid bits
  always_ff @(posedge clk) begin
    if (wr_go && !wr_same) tag_r[wr_idx] <= wr_tag;
  end

  // Valid and poison bits: flops so that a clear empties all lines at once
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < LINES; i++) begin
        vld_r[i] <= '0;
        psn_r[i] <= '0;
      end
    end else if (wr_go) begin
      if (wr_same) begin
        vld_r[wr_idx] <= vld_r[wr_idx] | wr_be;
        psn_r[wr_idx] <= (psn_r[wr_idx] & ~wr_be) | wr_fill;
      end else begin
        vld_r[wr_idx] <= wr_be;
        psn_r[wr_idx] <= wr_fill;
      end
    end
  end

  logic hit_c, inv_c;

  always_comb begin
    hit_c = rd_en && (rd_be != '0)
            && ((rd_be & ~vld_r[rd_idx]) == '0)
            && (tag_r[rd_idx] == rd_tag);
    inv_c = hit_c && ((psn_r[rd_idx] & rd_be) != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      hit_q <= hit_c;
      inv_q <= inv_c;
    end
  end
endmodule

// File: rtl/sfc_data.sv
module sfc_data #(
  parameter int unsigned LINES = 64,
  parameter int unsigned LANES = 8,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              re,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q
);
  // One narrow RAM per byte lane keeps each lane a plain simple-dual-port memory
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] mem [LINES];
    logic [7:0] q_l;

    always_ff @(posedge clk) begin
      if (we && wr_be[b]) mem[wr_idx] <= wr_data[8*b +: 8];
      if (re) q_l <= mem[rd_idx];
    end

    assign rd_q[8*b +: 8] = q_l;
  end
endmodule

// File: rtl/spec_fwd_cache.sv
module spec_fwd_cache #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINES  = 64,
  parameter int unsigned LANES  = 8,
  localparam int unsigned OFF_W  = $clog2(LANES),
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_inv,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LANES-1:0]  rd_be,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_inv
);
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [TAG_W-1:0] wr_tag, rd_tag;
  logic             unused_off;

  assign wr_idx = wr_addr[OFF_W +: IDX_W];
  assign rd_idx = rd_addr[OFF_W +: IDX_W];
  assign wr_tag = wr_addr[ADDR_W-1 -: TAG_W];
  assign rd_tag = rd_addr[ADDR_W-1 -: TAG_W];
  assign unused_off = ^{wr_addr[OFF_W-1:0], rd_addr[OFF_W-1:0]};

  sfc_meta #(.LINES(LINES), .LANES(LANES), .TAG_W(TAG_W)) u_meta (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_tag (wr_tag),
    .wr_be  (wr_be),
    .wr_inv (wr_inv),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .rd_tag (rd_tag),
    .rd_be  (rd_be),
    .hit_q  (rd_hit),
    .inv_q  (rd_inv)
  );

  sfc_data #(.LINES(LINES), .LANES(LANES)) u_data (
    .clk     (clk),
    .we      (wr_en && !clr && !rst),
    .wr_idx  (wr_idx),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .re      (rd_en),
    .rd_idx  (rd_idx),
    .rd_q    (rd_data)
  );
endmodule

// File: rtl/spec_fwd_cache_chk.sv
module spec_fwd_cache_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANES  = 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LANES-1:0]  wr_be,
  input logic              wr_inv,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [LANES-1:0]  rd_be,
  input logic              rd_hit,
  input logic              rd_inv
);
  logic                    wv_q, winv_q, clr_q;
  logic [LANES-1:0]        wbe_q;
  logic [ADDR_W-OFF_W-1:0] wline_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wv_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      wv_q  <= wr_en && (wr_be != '0) && !clr;
      clr_q <= clr;
    end
    winv_q  <= wr_inv;
    wbe_q   <= wr_be;
    wline_q <= wr_addr[ADDR_W-1:OFF_W];
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> !rd_hit && !rd_inv);

  // R2
  write_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (wv_q && rd_en && rd_be != '0 && (rd_be & ~wbe_q) == '0
     && rd_addr[ADDR_W-1:OFF_W] == wline_q) |=> rd_hit);

  // R4
  fresh_poison_chk: assert property (@(posedge clk) disable iff (rst)
    (wv_q && rd_en && rd_be != '0 && (rd_be & ~wbe_q) == '0
     && rd_addr[ADDR_W-1:OFF_W] == wline_q) |=> rd_inv == $past(winv_q));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !rd_hit);

  // R9
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || rd_be == '0) |=> !rd_hit);

  // R9
  inv_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |-> !rd_inv);
endmodule

bind spec_fwd_cache spec_fwd_cache_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clr     (clr),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_be   (wr_be),
  .wr_inv  (wr_inv),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rd_be   (rd_be),
  .rd_hit  (rd_hit),
  .rd_inv  (rd_inv)
);

// File: tb/test_spec_fwd_cache.sv
module test_spec_fwd_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic        wr_inv = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [7:0]  rd_be = '0;
  logic        rd_hit;
  logic [63:0] rd_data;
  logic        rd_inv;

  always #2 clk = ~clk;

  spec_fwd_cache i_spec_fwd_cache (.*);

  int n_chk = 0;
  int n_bad = 0;

  // Model: lines held by line address (addr >> 3)
  logic [63:0] m_dat [longint];
  logic [7:0]  m_vld [longint];
  logic [7:0]  m_psn [longint];

  function automatic logic [63:0] mask64(input logic [7:0] be);
    logic [63:0] m = '0;
    for (int b = 0; b < 8; b++) if (be[b]) m[8*b +: 8] = 8'hff;
    return m;
  endfunction

  task automatic model_write(input logic [31:0] a, input logic [7:0] be,
                             input logic [63:0] d, input logic p);
    longint k = longint'(a >> 3);
    longint victim = -1;
    if (be == 0) return;
    if (!m_vld.exists(k)) begin
      foreach (m_vld[q]) if ((q & 63) == (k & 63)) victim = q;
      if (victim >= 0) begin
        m_vld.delete(victim); m_psn.delete(victim); m_dat.delete(victim);
      end
      m_vld[k] = 8'h00; m_psn[k] = 8'h00; m_dat[k] = '0;
    end
    m_vld[k] = m_vld[k] | be;
    m_psn[k] = (m_psn[k] & ~be) | (p ? be : 8'h00);
    m_dat[k] = (m_dat[k] & ~mask64(be)) | (d & mask64(be));
  endtask

  task automatic check(input string req, input logic cond, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, predict read-first, update model, compare next negedge
  task automatic step(input string req,
                      input logic c, input logic we, input logic [31:0] wa,
                      input logic [7:0] wb, input logic [63:0] wd, input logic wp,
                      input logic re, input logic [31:0] ra, input logic [7:0] rb);
    longint k = longint'(ra >> 3);
    logic eh, ei;
    logic [63:0] ed;
    clr = c; wr_en = we; wr_addr = wa; wr_be = wb; wr_data = wd; wr_inv = wp;
    rd_en = re; rd_addr = ra; rd_be = rb;
    eh = re && rb != 0 && m_vld.exists(k) && ((rb & ~m_vld[k]) == 0);
    ei = eh && ((m_psn[k] & rb) != 0);
    ed = eh ? (m_dat[k] & mask64(rb)) : '0;
    @(posedge clk);
    if (c) begin m_vld.delete(); m_psn.delete(); m_dat.delete(); end
    else if (we) model_write(wa, wb, wd, wp);
    @(negedge clk);
    check({req, " hit"}, rd_hit === eh, 64'(rd_hit), 64'(eh));
    check({req, " inv"}, rd_inv === ei, 64'(rd_inv), 64'(ei));
    if (eh) check({req, " data"}, (rd_data & mask64(rb)) === ed,
                  rd_data & mask64(rb), ed);
  endtask

  task automatic wr(input string req, input logic [31:0] a, input logic [7:0] be,
                    input logic [63:0] d, input logic p);
    step(req, 0, 1, a, be, d, p, 0, '0, '0);
  endtask

  task automatic rd(input string req, input logic [31:0] a, input logic [7:0] be);
    step(req, 0, 0, '0, '0, '0, 0, 1, a, be);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset hit", rd_hit === 1'b0, 64'(rd_hit), 0);
    check("R1 reset inv", rd_inv === 1'b0, 64'(rd_inv), 0);
    rd("R1", 32'h0000_0100, 8'hff);

    // R2 full-line write then read
    wr("R2", 32'h0000_0100, 8'hff, 64'h0123_4567_89ab_cdef, 0);
    rd("R2", 32'h0000_0100, 8'hff);
    rd("R2", 32'h0000_0105, 8'h30);

    // R4 poison per byte, R5 partial update
    wr("R4", 32'h0000_0208, 8'h0f, 64'h0000_0000_dead_beef, 1);
    rd("R4", 32'h0000_0208, 8'h03);
    wr("R5", 32'h0000_0208, 8'hf0, 64'hcafe_f00d_0000_0000, 0);
    rd("R4", 32'h0000_0208, 8'hf0);
    rd("R4", 32'h0000_0208, 8'hff);
    rd("R5", 32'h0000_0208, 8'h0f);
    wr("R5", 32'h0000_0208, 8'h04, 64'h0000_0000_0077_0000, 0);
    rd("R5", 32'h0000_0208, 8'h0c);
    rd("R5", 32'h0000_0208, 8'h08);

    // R3 coverage and tag conditions
    wr("R3", 32'h0000_0308, 8'h0f, 64'h1111_2222_3333_4444, 0);
    rd("R3", 32'h0000_0308, 8'h1f);
    rd("R3", 32'h0000_0508, 8'h01);

    // R5 empty mask ignored, R6 conflict replacement
    wr("R5", 32'h0000_0408, 8'h00, 64'hffff_ffff_ffff_ffff, 1);
    rd("R5", 32'h0000_0208, 8'hff);
    wr("R6", 32'h0000_0408, 8'h01, 64'h0000_0000_0000_00a5, 1);
    rd("R6", 32'h0000_0208, 8'h01);
    rd("R6", 32'h0000_0408, 8'h01);
    rd("R6", 32'h0000_0408, 8'h02);

    // R8 same-cycle write and read: old contents
    step("R8", 0, 1, 32'h0000_0610, 8'hff, 64'h5555_aaaa_5555_aaaa, 0, 1, 32'h0000_0610, 8'hff);
    rd("R8", 32'h0000_0610, 8'hff);

    // R9 idle reads
    step("R9", 0, 0, '0, '0, '0, 0, 0, 32'h0000_0100, 8'hff);
    rd("R9", 32'h0000_0100, 8'h00);

    // R7 clear with write in the same cycle, read in the clear cycle
    step("R7", 1, 1, 32'h0000_0700, 8'hff, 64'h1, 0, 1, 32'h0000_0100, 8'hff);
    rd("R7", 32'h0000_0100, 8'hff);
    rd("R7", 32'h0000_0700, 8'h01);
    rd("R7", 32'h0000_0610, 8'hff);

    // Random mix: 4 tags x 4 indices
    for (int i = 0; i < 600; i++) begin
      logic [31:0] wa, ra;
      wa = {21'h0, 2'($urandom), 6'($urandom % 4), 3'b000};
      ra = {21'h0, 2'($urandom), 6'($urandom % 4), 3'($urandom)};
      step("R3 R4 R5 R6 mix", ($urandom % 40) == 0, ($urandom % 2) == 0, wa,
           8'($urandom), {$urandom, $urandom}, 1'($urandom),
           ($urandom % 4) != 0, ra, 8'($urandom) & 8'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule